// File: doc/BRIEF.md
# Timer Compare Register Access Trap Router

This block decides, in a single combinational pass, what happens to one access to the physical timer compare register. It looks at the exception level the access comes from (0 to 3), the register width each higher level runs at, whether level 2 is enabled or in host mode, the trap-general bit, the timer and counter access-enable bits, the non-secure bit and the secure level-2 feature flag. From these it produces one outcome: permit the access to a named register bank, trap to level 1, trap to level 2, take a hypervisor trap, or treat the access as undefined. A syndrome code goes with each trap.

The checks run in a fixed priority order and the first one that matches wins. A permitted level-0 access in host mode does not go to the normal compare register. It is sent to one of the level-2 timer compare registers instead. Reads and writes take the same decision path. The only difference is which of the two enable strobes the block raises toward the register storage. The storage and the exception entry logic lie outside this block.

Top module: `ctimer_trap_router`

## Requirements
- R1: At level 0, when level 1 is 64-bit (`l1Narrow`=0), `l0Host`=0 and `l0UserEn`=0, the access traps with syndrome 0x04. It goes to level 2 (outcome 2) when `l2Active`=1, `l2Narrow`=0 and `trapGeneral`=1. Otherwise it goes to level 1 (outcome 1).
- R2: At level 0, when `l1Narrow`=1 and `l0UserEn`=0, the result depends on level 2:
  - `l2Active`=1, `l2Narrow`=0 and `trapGeneral`=1 give a level-2 trap with syndrome 0x04.
  - `l2Active`=1, `l2Narrow`=1 and `trapGeneral`=1 give a hypervisor trap (outcome 3) with syndrome 0x00.
  - Any other case is undefined (outcome 4) with syndrome 0x00.
- R3: At levels 0 and 1, if R1 and R2 did not match, `l2Active`=1, `l2Narrow`=0, `l2Host`=0 and `l1PhysEn`=0 give a level-2 trap with syndrome 0x04.
- R4: The next checks in priority each give a level-2 trap with syndrome 0x04:
  - `l2Host`=1 with `hostL1TimerEn`=0, at level 1 always and at level 0 only when `trapGeneral`=0.
  - Then, at level 0 only, `l0Host`=1 with `hostL0TimerEn`=0.
- R5: At levels 0 and 1, if no earlier check matched, `l2Active`=1, `l2Narrow`=1 and `l1PhysEn`=0 give a hypervisor trap with syndrome 0x04.
- R6: A level-0 access that passes every check with `l0Host`=1 goes to one of three banks:
  - the secure level-2 bank (bank 4) when `nsBit`=0 and `secL2Feature`=1;
  - the non-secure level-2 bank (bank 3) when `nsBit`=1;
  - the common bank (bank 0) otherwise.
- R7: Accesses at level 2 are always permitted, whatever the trap and enable bits are. A permitted access at level 1 or 2 goes to the non-secure bank (bank 1) when `l3Present`=1 and `l3Narrow`=1, and to the common bank (bank 0) otherwise.
- R8: Accesses at level 3 are always permitted. They go to the secure bank (bank 2) when `nsBit`=0 and to the non-secure bank (bank 1) when `nsBit`=1.
- R9: `rdEn` and `wrEn` follow `accessReq` and `accessWrite`, and only for a permitted outcome; both are 0 for any trap or undefined outcome. The outcome, syndrome and bank do not depend on `accessWrite`.
- R10: The outcome codes are permit 0, level-1 trap 1, level-2 trap 2, hypervisor trap 3 and undefined 4. The syndrome is 0x00 when the access is permitted. The bank is 0 whenever the outcome is not permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accessReq | input | 1 | An access is being presented |
| accessWrite | input | 1 | 1 for a write, 0 for a read |
| curLevel | input | 2 | Exception level of the access |
| l1Narrow | input | 1 | Level 1 runs in 32-bit mode |
| l2Active | input | 1 | Level 2 is enabled |
| l2Narrow | input | 1 | Level 2 runs in 32-bit mode |
| l2Host | input | 1 | Level 2 is in host mode |
| l0Host | input | 1 | Level 0 runs under a host-mode level 2 |
| l3Present | input | 1 | Level 3 is implemented |
| l3Narrow | input | 1 | Level 3 runs in 32-bit mode |
| trapGeneral | input | 1 | Trap-general-exception control bit |
| l0UserEn | input | 1 | Level-1 grant of physical timer access to level 0 |
| l1PhysEn | input | 1 | Level-2 grant of physical counter access to level 1 |
| hostL1TimerEn | input | 1 | Host-mode grant of physical timer access at level 1 |
| hostL0TimerEn | input | 1 | Host-mode grant of physical timer access at level 0 |
| nsBit | input | 1 | Non-secure state bit |
| secL2Feature | input | 1 | Secure level 2 is implemented |
| outcome | output | 3 | Decision code (R10) |
| syndrome | output | 8 | Trap syndrome code |
| bank | output | 3 | Target register bank for a permitted access |
| rdEn | output | 1 | Read strobe to the selected bank |
| wrEn | output | 1 | Write strobe to the selected bank |

## Verification
The hardest cases to reach are the ones where several trap conditions hold at once and only the priority order decides the result. Examples are a level-0 access with a 32-bit level 1 that the user-permit check catches before the counter check, and a host-mode redirect that a cleared host enable must block. Directed tasks set up these overlaps one at a time. A final sweep then walks through all 2^17 combinations of level, mode and enable bits and the access direction, and compares each one with a priority-ordered reference function written from the requirements.

// File: rtl/ctimer_trap_pkg.sv
package ctimer_trap_pkg;
  localparam int SYN_W = 8;
  localparam logic [SYN_W-1:0] SYN_TIMER = 8'h04;
  localparam logic [SYN_W-1:0] SYN_NONE  = 8'h00;

  typedef enum logic [2:0] {
    OUT_PERMIT = 3'd0,
    OUT_TRAP1  = 3'd1,
    OUT_TRAP2  = 3'd2,
    OUT_HYP    = 3'd3,
    OUT_UNDEF  = 3'd4
  } outcome_e;

  typedef enum logic [2:0] {
    BANK_COMMON = 3'd0,
    BANK_NSEC   = 3'd1,
    BANK_SEC    = 3'd2,
    BANK_L2NS   = 3'd3,
    BANK_L2SEC  = 3'd4
  } bank_e;

  // Strobes from the control decoder to the priority datapath
  typedef struct packed {
    logic userGate;
    logic userToL2;
    logic userNarrow;
    logic userToHyp;
    logic wideCounter;
    logic hostL1;
    logic hostL0;
    logic narrowCounter;
    logic redirSec;
    logic redirNs;
    logic pickSec;
    logic pickNs;
  } gate_t;
endpackage

// File: rtl/ctimer_trap_ctrl.sv
module ctimer_trap_ctrl
  import ctimer_trap_pkg::*;
(
  input  logic [1:0] curLevel,
  input  logic       l1Narrow,
  input  logic       l2Active,
  input  logic       l2Narrow,
  input  logic       l2Host,
  input  logic       l0Host,
  input  logic       l3Present,
  input  logic       l3Narrow,
  input  logic       trapGeneral,
  input  logic       l0UserEn,
  input  logic       l1PhysEn,
  input  logic       hostL1TimerEn,
  input  logic       hostL0TimerEn,
  input  logic       nsBit,
  input  logic       secL2Feature,
  output gate_t      gates
);
  logic atL0, atL1, atL2, atL3, lowLevel, l2Wide, l2Short;

  always_comb begin
    atL0     = (curLevel == 2'd0);
    atL1     = (curLevel == 2'd1);
    atL2     = (curLevel == 2'd2);
    atL3     = (curLevel == 2'd3);
    lowLevel = atL0 | atL1;
    l2Wide   = l2Active & ~l2Narrow;
    l2Short  = l2Active & l2Narrow;

    gates.userGate      = atL0 & ~l0UserEn & (l1Narrow | ~l0Host);
    gates.userToL2      = l2Wide & trapGeneral;
    gates.userNarrow    = l1Narrow;
    gates.userToHyp     = l2Short & trapGeneral;
    gates.wideCounter   = lowLevel & l2Wide & ~l2Host & ~l1PhysEn;
    gates.hostL1        = l2Host & ~hostL1TimerEn & (atL1 | (atL0 & ~trapGeneral));
    gates.hostL0        = atL0 & l0Host & ~hostL0TimerEn;
    gates.narrowCounter = lowLevel & l2Short & ~l1PhysEn;
    gates.redirSec      = atL0 & l0Host & ~nsBit & secL2Feature;
    gates.redirNs       = atL0 & l0Host & nsBit;
    gates.pickSec       = atL3 & ~nsBit;
    gates.pickNs        = ((atL1 | atL2) & l3Present & l3Narrow) | (atL3 & nsBit);
  end
endmodule

// File: rtl/ctimer_trap_dp.sv
module ctimer_trap_dp
  import ctimer_trap_pkg::*;
(
  input  gate_t            gates,
  input  logic             accessReq,
  input  logic             accessWrite,
  output outcome_e         outSel,
  output logic [SYN_W-1:0] synSel,
  output bank_e            bankSel,
  output logic             rdEn,
  output logic             wrEn
);
  always_comb begin
    outSel  = OUT_PERMIT;
    synSel  = SYN_NONE;
    bankSel = BANK_COMMON;
    if (gates.userGate) begin
      if (gates.userToL2) begin
        outSel = OUT_TRAP2;
        synSel = SYN_TIMER;
      end else if (gates.userNarrow) begin
        outSel = gates.userToHyp ? OUT_HYP : OUT_UNDEF;
      end else begin
        outSel = OUT_TRAP1;
        synSel = SYN_TIMER;
      end
    end else if (gates.wideCounter | gates.hostL1 | gates.hostL0) begin
      outSel = OUT_TRAP2;
      synSel = SYN_TIMER;
    end else if (gates.narrowCounter) begin
      outSel = OUT_HYP;
      synSel = SYN_TIMER;
    end else if (gates.redirSec) begin
      bankSel = BANK_L2SEC;
    end else if (gates.redirNs) begin
      bankSel = BANK_L2NS;
    end else if (gates.pickSec) begin
      bankSel = BANK_SEC;
    end else if (gates.pickNs) begin
      bankSel = BANK_NSEC;
    end
    rdEn = accessReq & (outSel == OUT_PERMIT) & ~accessWrite;
    wrEn = accessReq & (outSel == OUT_PERMIT) & accessWrite;
  end
endmodule

// File: rtl/ctimer_trap_router.sv
module ctimer_trap_router
  import ctimer_trap_pkg::*;
(
  input  logic       accessReq,
  input  logic       accessWrite,
  input  logic [1:0] curLevel,
  input  logic       l1Narrow,
  input  logic       l2Active,
  input  logic       l2Narrow,
  input  logic       l2Host,
  input  logic       l0Host,
  input  logic       l3Present,
  input  logic       l3Narrow,
  input  logic       trapGeneral,
  input  logic       l0UserEn,
  input  logic       l1PhysEn,
  input  logic       hostL1TimerEn,
  input  logic       hostL0TimerEn,
  input  logic       nsBit,
  input  logic       secL2Feature,
  output logic [2:0] outcome,
  output logic [7:0] syndrome,
  output logic [2:0] bank,
  output logic       rdEn,
  output logic       wrEn
);
  gate_t    gates;
  outcome_e outSel;
  bank_e    bankSel;
  logic [SYN_W-1:0] synSel;

  ctimer_trap_ctrl ctrl_i (
    .curLevel(curLevel), .l1Narrow(l1Narrow), .l2Active(l2Active),
    .l2Narrow(l2Narrow), .l2Host(l2Host), .l0Host(l0Host),
    .l3Present(l3Present), .l3Narrow(l3Narrow), .trapGeneral(trapGeneral),
    .l0UserEn(l0UserEn), .l1PhysEn(l1PhysEn), .hostL1TimerEn(hostL1TimerEn),
    .hostL0TimerEn(hostL0TimerEn), .nsBit(nsBit), .secL2Feature(secL2Feature),
    .gates(gates)
  );

  ctimer_trap_dp dp_i (
    .gates(gates), .accessReq(accessReq), .accessWrite(accessWrite),
    .outSel(outSel), .synSel(synSel), .bankSel(bankSel),
    .rdEn(rdEn), .wrEn(wrEn)
  );

  assign outcome  = outSel;
  assign syndrome = synSel;
  assign bank     = bankSel;
endmodule

// File: rtl/ctimer_trap_router_chk.sv
module ctimer_trap_router_chk (
  input logic       accessReq,
  input logic       accessWrite,
  input logic [1:0] curLevel,
  input logic       l1Narrow,
  input logic       l2Active,
  input logic       l2Narrow,
  input logic       l0Host,
  input logic       l0UserEn,
  input logic [2:0] outcome,
  input logic [7:0] syndrome,
  input logic [2:0] bank,
  input logic       rdEn,
  input logic       wrEn
);
  always_comb begin
    p_permit_quiet_r10: assert (outcome != 3'd0 || syndrome == 8'h00)
      else $error("permitted access carries a syndrome");
    p_trap_no_strobe_r9: assert (outcome == 3'd0 || (!rdEn && !wrEn && bank == 3'd0))
      else $error("trap outcome drives strobes or bank");
    p_strobe_dir_r9: assert (!(rdEn && wrEn) && (!rdEn || (accessReq && !accessWrite))
                             && (!wrEn || (accessReq && accessWrite)))
      else $error("strobe disagrees with access direction");
    p_level2_open_r7: assert (curLevel != 2'd2 || (outcome == 3'd0 && bank <= 3'd1))
      else $error("level-2 access not permitted to a level-2 bank");
    p_level3_bank_r8: assert (curLevel != 2'd3 || (outcome == 3'd0 && (bank == 3'd1 || bank == 3'd2)))
      else $error("level-3 access routed wrongly");
    p_l1trap_src_r1: assert (outcome != 3'd1 || (curLevel == 2'd0 && !l1Narrow && !l0UserEn))
      else $error("level-1 trap from wrong source");
    p_undef_src_r2: assert (outcome != 3'd4 || (curLevel == 2'd0 && l1Narrow && !l0UserEn))
      else $error("undefined outcome from wrong source");
    p_hyp_src_r5: assert (outcome != 3'd3 || (l2Active && l2Narrow))
      else $error("hypervisor trap without 32-bit level 2");
    p_redirect_src_r6: assert (bank < 3'd3 || (curLevel == 2'd0 && l0Host))
      else $error("level-2 bank selected outside host-mode level 0");
  end
endmodule

bind ctimer_trap_router ctimer_trap_router_chk chk_i (
  .accessReq(accessReq), .accessWrite(accessWrite), .curLevel(curLevel),
  .l1Narrow(l1Narrow), .l2Active(l2Active), .l2Narrow(l2Narrow),
  .l0Host(l0Host), .l0UserEn(l0UserEn), .outcome(outcome),
  .syndrome(syndrome), .bank(bank), .rdEn(rdEn), .wrEn(wrEn)
);

// File: tb/ctimer_trap_router_tb_top.sv
`timescale 1ns/1ps
module ctimer_trap_router_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic accessReq, accessWrite, l1Narrow, l2Active, l2Narrow, l2Host, l0Host;
  logic l3Present, l3Narrow, trapGeneral, l0UserEn, l1PhysEn;
  logic hostL1TimerEn, hostL0TimerEn, nsBit, secL2Feature;
  logic [1:0] curLevel;
  logic [2:0] outcome, bank;
  logic [7:0] syndrome;
  logic rdEn, wrEn;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  ctimer_trap_router dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 190000 && !finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog: actual run-on expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic base();
    accessReq = 1; accessWrite = 0; curLevel = 0; l1Narrow = 0; l2Active = 0;
    l2Narrow = 0; l2Host = 0; l0Host = 0; l3Present = 0; l3Narrow = 0;
    trapGeneral = 0; l0UserEn = 1; l1PhysEn = 1; hostL1TimerEn = 1;
    hostL0TimerEn = 1; nsBit = 0; secL2Feature = 0;
  endtask

  task automatic check(string tag, logic [2:0] eo, logic [7:0] es, logic [2:0] eb);
    #1;
    nChecks++;
    if (outcome !== eo || syndrome !== es || bank !== eb) begin
      nFails++;
      $display("FAIL %s: actual out=%0d syn=%h bank=%0d expected out=%0d syn=%h bank=%0d",
               tag, outcome, syndrome, bank, eo, es, eb);
    end
  endtask

  task automatic checkEn(string tag, logic er, logic ew);
    #1;
    nChecks++;
    if (rdEn !== er || wrEn !== ew) begin
      nFails++;
      $display("FAIL %s: actual rd=%b wr=%b expected rd=%b wr=%b", tag, rdEn, wrEn, er, ew);
    end
  endtask

  // Reference decision written from the requirement list, in priority order
  function automatic logic [13:0] refRes(logic [16:0] v);
    logic [1:0] lv; logic n1, a2, n2, h2, h0, p3, n3, tg, ue, pe, e1, e0, ns, s2;
    lv = v[1:0]; n1 = v[2]; a2 = v[3]; n2 = v[4]; h2 = v[5]; h0 = v[6];
    p3 = v[7]; n3 = v[8]; tg = v[9]; ue = v[10]; pe = v[11]; e1 = v[12];
    e0 = v[13]; ns = v[14]; s2 = v[15];
    if (lv == 2'd3) return {3'd0, 8'h00, ns ? 3'd1 : 3'd2};
    if (lv == 2'd2) return {3'd0, 8'h00, (p3 && n3) ? 3'd1 : 3'd0};
    if (lv == 2'd0 && !ue && !n1 && !h0)
      return (a2 && !n2 && tg) ? {3'd2, 8'h04, 3'd0} : {3'd1, 8'h04, 3'd0};
    if (lv == 2'd0 && !ue && n1) begin
      if (a2 && !n2 && tg) return {3'd2, 8'h04, 3'd0};
      if (a2 && n2 && tg)  return {3'd3, 8'h00, 3'd0};
      return {3'd4, 8'h00, 3'd0};
    end
    if (a2 && !n2 && !h2 && !pe) return {3'd2, 8'h04, 3'd0};
    if (h2 && !e1 && (lv == 2'd1 || !tg)) return {3'd2, 8'h04, 3'd0};
    if (lv == 2'd0 && h0 && !e0) return {3'd2, 8'h04, 3'd0};
    if (a2 && n2 && !pe) return {3'd3, 8'h04, 3'd0};
    if (lv == 2'd0) begin
      if (h0 && !ns && s2) return {3'd0, 8'h00, 3'd4};
      if (h0 && ns) return {3'd0, 8'h00, 3'd3};
      return {3'd0, 8'h00, 3'd0};
    end
    return {3'd0, 8'h00, (p3 && n3) ? 3'd1 : 3'd0};
  endfunction

  task automatic t_idle();
    base();
    check("R10 all-enabled level 0", 3'd0, 8'h00, 3'd0);
    checkEn("R9 read strobe", 1'b1, 1'b0);
  endtask

  task automatic t_r1();
    base(); l0UserEn = 0;
    check("R1 trap to level 1", 3'd1, 8'h04, 3'd0);
    l2Active = 1; trapGeneral = 1;
    check("R1 trap to level 2", 3'd2, 8'h04, 3'd0);
    base(); l0UserEn = 0; l0Host = 1; nsBit = 1;
    check("R1 host skips user check, R6 redirect", 3'd0, 8'h00, 3'd3);
  endtask

  task automatic t_r2();
    base(); l1Narrow = 1; l0UserEn = 0;
    check("R2 undefined", 3'd4, 8'h00, 3'd0);
    l2Active = 1; l2Narrow = 1; trapGeneral = 1; l1PhysEn = 0;
    check("R2 hyp code 0 beats R5", 3'd3, 8'h00, 3'd0);
    l2Narrow = 0;
    check("R2 wide level 2", 3'd2, 8'h04, 3'd0);
  endtask

  task automatic t_r3();
    base(); curLevel = 1; l2Active = 1; l1PhysEn = 0;
    check("R3 level 1 counter trap", 3'd2, 8'h04, 3'd0);
    l2Host = 1;
    check("R3 host exempt", 3'd0, 8'h00, 3'd0);
  endtask

  task automatic t_r4();
    base(); l2Host = 1; hostL1TimerEn = 0;
    check("R4 host L1 timer at level 0", 3'd2, 8'h04, 3'd0);
    trapGeneral = 1;
    check("R4 trapGeneral masks it at level 0", 3'd0, 8'h00, 3'd0);
    curLevel = 1;
    check("R4 level 1 ignores trapGeneral", 3'd2, 8'h04, 3'd0);
    base(); l0Host = 1; hostL0TimerEn = 0; nsBit = 1;
    check("R4 host L0 timer blocks redirect", 3'd2, 8'h04, 3'd0);
  endtask

  task automatic t_r5();
    base(); curLevel = 1; l2Active = 1; l2Narrow = 1; l1PhysEn = 0;
    check("R5 hyp code 4", 3'd3, 8'h04, 3'd0);
  endtask

  task automatic t_r6();
    base(); l0Host = 1; secL2Feature = 1;
    check("R6 secure level-2 bank", 3'd0, 8'h00, 3'd4);
    secL2Feature = 0;
    check("R6 no feature falls to common", 3'd0, 8'h00, 3'd0);
  endtask

  task automatic t_r7();
    base(); curLevel = 2; l0UserEn = 0; l2Active = 1; l1PhysEn = 0;
    l2Host = 1; hostL1TimerEn = 0; l3Present = 1; l3Narrow = 1;
    check("R7 level 2 permitted to NS bank", 3'd0, 8'h00, 3'd1);
    l3Present = 0;
    check("R7 level 2 common", 3'd0, 8'h00, 3'd0);
    base(); curLevel = 1; l3Present = 1; l3Narrow = 1;
    check("R7 level 1 NS bank", 3'd0, 8'h00, 3'd1);
  endtask

  task automatic t_r8();
    base(); curLevel = 3;
    check("R8 secure bank", 3'd0, 8'h00, 3'd2);
    nsBit = 1;
    check("R8 non-secure bank", 3'd0, 8'h00, 3'd1);
  endtask

  task automatic t_r9();
    base(); accessWrite = 1;
    checkEn("R9 write strobe", 1'b0, 1'b1);
    check("R9 write same outcome", 3'd0, 8'h00, 3'd0);
    accessReq = 0;
    checkEn("R9 idle no strobe", 1'b0, 1'b0);
    accessReq = 1; l0UserEn = 0;
    checkEn("R9 trap no strobe", 1'b0, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < (1 << 17); i++) begin
      logic [16:0] v;
      logic [13:0] r;
      v = i[16:0];
      curLevel = v[1:0]; l1Narrow = v[2]; l2Active = v[3]; l2Narrow = v[4];
      l2Host = v[5]; l0Host = v[6]; l3Present = v[7]; l3Narrow = v[8];
      trapGeneral = v[9]; l0UserEn = v[10]; l1PhysEn = v[11];
      hostL1TimerEn = v[12]; hostL0TimerEn = v[13]; nsBit = v[14];
      secL2Feature = v[15]; accessWrite = v[16]; accessReq = 1;
      r = refRes(v);
      #1;
      nChecks++;
      if (outcome !== r[13:11] || syndrome !== r[10:3] || bank !== r[2:0] ||
          rdEn !== (r[13:11] == 3'd0 && !v[16]) || wrEn !== (r[13:11] == 3'd0 && v[16])) begin
        nFails++;
        $display("FAIL R10 sweep v=%h: actual out=%0d syn=%h bank=%0d rd=%b wr=%b expected out=%0d syn=%h bank=%0d",
                 v, outcome, syndrome, bank, rdEn, wrEn, r[13:11], r[10:3], r[2:0]);
      end
      #1;
    end
  endtask

  initial begin
    base();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_idle();
    t_r1();
    t_r2();
    t_r3();
    t_r4();
    t_r5();
    t_r6();
    t_r7();
    t_r8();
    t_r9();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule